// File: doc/BRIEF.md
# Sigma-delta conversion restart controller

This block sits behind a sigma-delta decimation filter and turns its stream of output-rate samples into data software can use. A conversion is started either by writing a fixed 16-bit key value to a key register or, when hardware triggering is enabled, by a pulse on an external trigger pin. After each start the block throws away a programmable number of output samples while the filter settles. Once that count has run out it raises a data-valid status and stores every further sample in a small FIFO.

The FIFO reports its fill level and an empty flag. It raises an interrupt or a DMA request, chosen by a control bit, while the level is at or above a programmed threshold. Software pops one sample per read strobe. A `rd_safe` status rises two cycles after the empty flag clears, which marks the earliest point at which a read is guaranteed to return settled data.

The sample input is a valid/ready stream that never applies back-pressure: `smp_ready` is tied high, because the decimator cannot stall. A sample offered while the FIFO is full is dropped and recorded in a sticky overflow flag. The read side is a plain register-read strobe rather than a handshake, because reading an empty FIFO is a defined, flagged event.

Top module: `sdc_restart_ctrl`

## Requirements
- R1: With `cfg_enable`=1 and `cfg_trig_en`=0, a `key_wr` strobe carrying `key_data`=16'h5AF0 starts a conversion. A key write with any other value leaves the FIFO contents and `data_valid` unchanged.
- R2: With `cfg_trig_en`=1, a one-cycle `hw_trig` pulse starts a conversion and key writes are ignored. With `cfg_trig_en`=0, `hw_trig` is ignored.
- R3: While `cfg_enable`=0, `data_valid` is 0, start events are ignored and no sample is stored. After re-enabling, the block stays idle until the next start event.
- R4: After a start, the next `cfg_settle` accepted samples are discarded, and `data_valid` rises on the clock edge that takes the last of them. With `cfg_settle`=0, `data_valid` rises on the start edge itself.
- R5: A start event while settling or running clears `data_valid`, restarts the settling count and flushes the FIFO. A start takes priority over a sample or read in the same cycle.
- R6: While `data_valid`=1, each sample with `smp_valid`=1 is stored in arrival order. `fifo_empty` falls on the edge that stores the first sample. `smp_ready` is always 1.
- R7: The FIFO holds DEPTH (8) entries. A sample arriving while the FIFO holds 8 entries is dropped and sets the sticky `ovf_flag`.
- R8: With `cfg_threshold` non-zero, a request is active while `fifo_level` >= `cfg_threshold`. It appears on `irq` when `cfg_dma_sel`=0 and on `dma_req` when `cfg_dma_sel`=1, and it drops once reads bring the level below the threshold.
- R9: A `rd_en` strobe on a non-empty FIFO pops the oldest entry, which appears on `rd_data` after that edge. On an empty FIFO, `rd_data` keeps the last value read and the sticky `udf_flag` sets.
- R10: A one-cycle pulse on `clr_ovf` or `clr_udf` clears the matching sticky flag. A new setting event in the same cycle wins.
- R11: `rd_safe` is 1 only from the second clock edge after `fifo_empty` falls, and it drops as soon as the FIFO is empty again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Module enable |
| cfg_trig_en | input | 1 | Select hardware trigger instead of key write |
| cfg_dma_sel | input | 1 | 1: threshold raises DMA request, 0: interrupt |
| cfg_settle | input | SW (8) | Samples discarded after each start |
| cfg_threshold | input | LW (4) | FIFO level threshold, 0 disables the request |
| key_wr | input | 1 | Key register write strobe |
| key_data | input | 16 | Key register write value |
| hw_trig | input | 1 | External trigger pulse |
| smp_valid | input | 1 | Decimated sample valid |
| smp_data | input | DW (16) | Decimated sample |
| smp_ready | output | 1 | Always 1, no back-pressure |
| rd_en | input | 1 | Converted-data read strobe, pops the FIFO |
| rd_data | output | DW (16) | Last sample read |
| clr_ovf | input | 1 | Write-1 clear of overflow flag |
| clr_udf | input | 1 | Write-1 clear of underflow flag |
| data_valid | output | 1 | Settling complete, samples are stored |
| fifo_empty | output | 1 | FIFO empty |
| fifo_level | output | LW (4) | FIFO fill level |
| rd_safe | output | 1 | Read is safe, 2 cycles after empty clears |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |
| irq | output | 1 | Threshold interrupt |
| dma_req | output | 1 | Threshold DMA request |

## Verification
The bench restarts a conversion in the middle of settling and checks that `data_valid` stays low for a full fresh count. A design that only reset the flag, and not the count, would declare data valid too early. It writes near-miss key values and fires the trigger pin with the wrong enable. A design with a loose key compare or ungated triggers would flush stored data, and the bench sees the level drop. It overfills the FIFO and then drains it, so a design that overwrote instead of dropping would return the wrong oldest entries. It also reads an empty FIFO, and a design that popped stale memory would change `rd_data`. Finally it steps `rd_safe` cycle by cycle after the first push and flips the request routing bit at threshold, which catches a delay counted off by one or a request driven to both outputs.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam logic [15:0] RESTART_KEY = 16'h5AF0;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } settle_st_t;
endpackage

// File: rtl/sdc_restart_src.sv
module sdc_restart_src
  import sdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        trig_en,
  input  logic        key_wr,
  input  logic [15:0] key_data,
  input  logic        hw_trig,
  output logic        restart_o
);
  logic key_hit;

  assign key_hit   = key_wr && (key_data == RESTART_KEY);
  // Trigger enable swaps the start source rather than adding one.
  assign restart_o = enable && (trig_en ? hw_trig : key_hit);

  // R1: a wrong key value never starts a conversion
  a_r1_bad_key_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != RESTART_KEY && !hw_trig) |-> !restart_o);

  // R2: trigger pin alone is ignored unless triggering is enabled
  a_r2_trig_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_trig && !trig_en && !key_wr) |-> !restart_o);
endmodule

// File: rtl/sdc_settle.sv
module sdc_settle
  import sdc_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          restart,
  input  logic          smp_valid,
  input  logic [SW-1:0] settle_len,
  output logic          data_valid,
  output logic          push_o
);
  settle_st_t     st;
  logic [SW-1:0]  cnt;
  logic [SW:0]    cnt_nxt;

  assign cnt_nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (!enable) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (restart) begin
      cnt <= '0;
      st  <= (settle_len == '0) ? ST_RUN : ST_SETTLE;
    end else if (st == ST_SETTLE && smp_valid) begin
      if (cnt_nxt == {1'b0, settle_len}) begin
        st  <= ST_RUN;
        cnt <= '0;
      end else begin
        cnt <= cnt_nxt[SW-1:0];
      end
    end
  end

  assign data_valid = (st == ST_RUN);
  assign push_o     = enable && smp_valid && (st == ST_RUN) && !restart;

  // R4: data-valid only rises on a discarded sample or on a start edge
  a_r4_valid_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> ($past(smp_valid) || $past(restart)));

  // R3: disabled block never reports valid data on the next cycle
  a_r3_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !data_valid);

  // R5: a start with a non-zero settle count clears data-valid
  a_r5_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && settle_len != '0) |=> !data_valid);
endmodule

// File: rtl/sdc_fifo.sv
module sdc_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] count;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == LW'(DEPTH));
  assign empty   = (count == '0);
  assign level   = count;
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= ptr_inc(wptr);
      if (do_pop)  rptr <= ptr_inc(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (do_pop) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (push && full && !flush) ovf <= 1'b1;
      else if (clr_ovf)           ovf <= 1'b0;
      if (pop && empty && !flush) udf <= 1'b1;
      else if (clr_udf)           udf <= 1'b0;
    end
  end

  // R7: fill level never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LW'(DEPTH));

  // R7: a sample offered at full is dropped and flagged
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (ovf && count == LW'(DEPTH)));

  // R9: read of an empty FIFO holds data and flags underflow
  a_r9_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !flush) |=> (udf && $stable(rd_data)));

  // R5: a flush empties the FIFO
  a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/sdc_restart_ctrl.sv
module sdc_restart_ctrl #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int SW    = 8,
  localparam int LW   = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic          cfg_trig_en,
  input  logic          cfg_dma_sel,
  input  logic [SW-1:0] cfg_settle,
  input  logic [LW-1:0] cfg_threshold,
  input  logic          key_wr,
  input  logic [15:0]   key_data,
  input  logic          hw_trig,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          smp_ready,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic          data_valid,
  output logic          fifo_empty,
  output logic [LW-1:0] fifo_level,
  output logic          rd_safe,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          irq,
  output logic          dma_req
);
  logic       restart;
  logic       push;
  logic       req_on;
  logic [1:0] safe_cnt;

  assign smp_ready = 1'b1;

  sdc_restart_src u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg_enable),
    .trig_en  (cfg_trig_en),
    .key_wr   (key_wr),
    .key_data (key_data),
    .hw_trig  (hw_trig),
    .restart_o(restart)
  );

  sdc_settle #(.SW(SW)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_enable),
    .restart   (restart),
    .smp_valid (smp_valid),
    .settle_len(cfg_settle),
    .data_valid(data_valid),
    .push_o    (push)
  );

  sdc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (restart),
    .push     (push),
    .push_data(smp_data),
    .pop      (rd_en),
    .clr_ovf  (clr_ovf),
    .clr_udf  (clr_udf),
    .rd_data  (rd_data),
    .level    (fifo_level),
    .empty    (fifo_empty),
    .ovf      (ovf_flag),
    .udf      (udf_flag)
  );

  // Read-safety delay: counts edges since the empty flag fell.
  always_ff @(posedge clk) begin
    if (!rst_n || fifo_empty) safe_cnt <= '0;
    else if (safe_cnt != 2'd2) safe_cnt <= safe_cnt + 1'b1;
  end
  assign rd_safe = (safe_cnt == 2'd2) && !fifo_empty;

  assign req_on  = cfg_enable && (cfg_threshold != '0) && (fifo_level >= cfg_threshold);
  assign irq     = req_on && !cfg_dma_sel;
  assign dma_req = req_on && cfg_dma_sel;

  // R8: the request is routed to one output at most
  a_r8_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq, dma_req}));

  // R11: safe-read status follows at least two non-empty cycles
  a_r11_safe_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_safe) |-> (!$past(fifo_empty) && !$past(fifo_empty, 2)));

  // R6: the sample input never back-pressures
  a_r6_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready);
endmodule

// File: tb/tb_sdc_restart_ctrl.sv
module tb_sdc_restart_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_trig_en = 1'b0, cfg_dma_sel = 1'b0;
  logic [7:0]  cfg_settle = 8'd3;
  logic [3:0]  cfg_threshold = 4'd4;
  logic        key_wr = 1'b0, hw_trig = 1'b0, smp_valid = 1'b0, rd_en = 1'b0;
  logic [15:0] key_data = '0, smp_data = '0;
  logic        clr_ovf = 1'b0, clr_udf = 1'b0;
  logic        smp_ready, data_valid, fifo_empty, rd_safe, ovf_flag, udf_flag, irq, dma_req;
  logic [15:0] rd_data;
  logic [3:0]  fifo_level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdc_restart_ctrl dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  task automatic key(input logic [15:0] v);
    key_wr = 1'b1; key_data = v;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic trig();
    hw_trig = 1'b1;
    @(negedge clk); hw_trig = 1'b0;
  endtask

  task automatic sample(input logic [15:0] v);
    smp_valid = 1'b1; smp_data = v;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic read(output logic [15:0] v);
    rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic t_reset();
    chk_eq("R6 reset empty", fifo_empty, 1);
    chk_eq("R4 reset data_valid", data_valid, 0);
    chk_eq("R6 ready", smp_ready, 1);
    chk_eq("R8 reset irq/dma", {irq, dma_req}, 0);
    chk_eq("R7 reset flags", {ovf_flag, udf_flag}, 0);
  endtask

  task automatic t_key_settle();
    logic [15:0] v;
    key(16'h5AF0);
    chk_eq("R1 key start settling", data_valid, 0);
    sample(16'h0011); sample(16'h0022);
    chk_eq("R4 still settling", data_valid, 0);
    sample(16'h0033);
    chk_eq("R4 valid after settle", data_valid, 1);
    chk_eq("R4 settle samples discarded", fifo_empty, 1);
    sample(16'h0044);
    chk_eq("R6 empty falls", fifo_empty, 0);
    chk_eq("R11 not safe at once", rd_safe, 0);
    @(negedge clk);
    chk_eq("R11 not safe after 1", rd_safe, 0);
    @(negedge clk);
    chk_eq("R11 safe after 2", rd_safe, 1);
    read(v);
    chk_eq("R9 read data", v, 16'h0044);
    chk_eq("R11 safe drops", rd_safe, 0);
  endtask

  task automatic t_bad_key();
    logic [15:0] v;
    sample(16'h0055);
    key(16'h1234);
    chk_eq("R1 bad key keeps level", fifo_level, 1);
    key(16'h5AF1);
    chk_eq("R1 near key keeps level", fifo_level, 1);
    chk_eq("R1 near key keeps valid", data_valid, 1);
    read(v);
    chk_eq("R1 data intact", v, 16'h0055);
  endtask

  task automatic t_settle_zero();
    cfg_settle = 8'd0;
    key(16'h5AF0);
    chk_eq("R4 zero settle valid", data_valid, 1);
    sample(16'h0066);
    chk_eq("R4 zero settle stores", fifo_level, 1);
    cfg_settle = 8'd3;
  endtask

  task automatic t_restart_flush();
    logic [15:0] v;
    key(16'h5AF0);
    chk_eq("R5 flush level", fifo_level, 0);
    chk_eq("R5 valid cleared", data_valid, 0);
    sample(16'h0001); sample(16'h0002);
    key(16'h5AF0);
    sample(16'h0003); sample(16'h0004);
    chk_eq("R5 count restarted", data_valid, 0);
    sample(16'h0005);
    chk_eq("R5 valid after fresh count", data_valid, 1);
    chk_eq("R5 nothing stored while settling", fifo_level, 0);
    sample(16'h0077);
    read(v);
    chk_eq("R6 data after restart", v, 16'h0077);
  endtask

  task automatic t_trigger();
    logic [15:0] v;
    cfg_trig_en = 1'b1;
    sample(16'h0088);
    key(16'h5AF0);
    chk_eq("R2 key ignored with trigger", fifo_level, 1);
    trig();
    chk_eq("R2 trigger flushes", fifo_level, 0);
    chk_eq("R2 trigger restarts", data_valid, 0);
    cfg_settle = 8'd0;
    trig();
    chk_eq("R2 trigger start", data_valid, 1);
    sample(16'h0099);
    cfg_trig_en = 1'b0;
    trig();
    chk_eq("R2 trigger ignored when off", fifo_level, 1);
    read(v);
    chk_eq("R2 data kept", v, 16'h0099);
  endtask

  task automatic t_threshold();
    logic [15:0] v;
    cfg_dma_sel = 1'b0;
    for (int i = 1; i <= 3; i++) sample(16'(i));
    chk_eq("R8 below threshold", {irq, dma_req}, 2'b00);
    sample(16'd4);
    chk_eq("R8 irq at threshold", {irq, dma_req}, 2'b10);
    cfg_dma_sel = 1'b1;
    @(negedge clk);
    chk_eq("R8 dma routed", {irq, dma_req}, 2'b01);
    read(v);
    chk_eq("R6 order first", v, 1);
    chk_eq("R8 drops below", dma_req, 0);
    sample(16'd5);
    chk_eq("R8 rises again", dma_req, 1);
    for (int i = 2; i <= 5; i++) begin
      read(v);
      chk_eq("R6 order", v, 32'(i));
    end
    cfg_dma_sel = 1'b0;
  endtask

  task automatic t_overflow();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) sample(16'hA0 + 16'(i));
    chk_eq("R7 full level", fifo_level, 8);
    chk_eq("R7 no ovf yet", ovf_flag, 0);
    sample(16'h00FF);
    chk_eq("R7 ovf set", ovf_flag, 1);
    chk_eq("R7 level held", fifo_level, 8);
    for (int i = 0; i < 8; i++) begin
      read(v);
      chk_eq("R7 dropped not overwritten", v, 32'(16'hA0 + i));
    end
  endtask

  task automatic t_underflow();
    logic [15:0] v;
    read(v);
    chk_eq("R9 hold on empty", v, 16'h00A7);
    chk_eq("R9 udf set", udf_flag, 1);
  endtask

  task automatic t_sticky();
    clr_ovf = 1'b1; @(negedge clk); clr_ovf = 1'b0;
    chk_eq("R10 ovf cleared", ovf_flag, 0);
    chk_eq("R10 udf kept", udf_flag, 1);
    clr_udf = 1'b1; rd_en = 1'b1; @(negedge clk); clr_udf = 1'b0; rd_en = 1'b0;
    chk_eq("R10 set wins over clear", udf_flag, 1);
    clr_udf = 1'b1; @(negedge clk); clr_udf = 1'b0;
    chk_eq("R10 udf cleared", udf_flag, 0);
  endtask

  task automatic t_disable();
    cfg_enable = 1'b0;
    @(negedge clk);
    chk_eq("R3 disabled not valid", data_valid, 0);
    sample(16'h0101);
    chk_eq("R3 no store disabled", fifo_level, 0);
    cfg_settle = 8'd0;
    key(16'h5AF0);
    chk_eq("R3 key ignored disabled", data_valid, 0);
    cfg_enable = 1'b1;
    @(negedge clk);
    chk_eq("R3 idle after enable", data_valid, 0);
    sample(16'h0102);
    chk_eq("R3 idle stores nothing", fifo_level, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_enable = 1'b1;
    @(negedge clk);
    t_reset();
    t_key_settle();
    t_bad_key();
    t_settle_zero();
    t_restart_flush();
    t_trigger();
    t_threshold();
    t_overflow();
    t_underflow();
    t_sticky();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule